// File: doc/BRIEF.md
# Shifting Issue Window Grouper

This block holds four decoded instructions in a window organised as a shift register. Every cycle it examines the window from the head and picks an in-order issue group. The group is limited by a fixed mix of execution unit classes, by a rule on the last group position, and by register dependences. For each slot of the window it reports whether that slot issues and which execution unit takes it.

At the clock edge the instructions that were not picked move toward the head. New instructions from fetch then enter the slots freed at the tail. The window therefore refills after every group and does not wait until it has drained completely. Fetch offers up to four instructions with a count, and the block reports how many of them it took in the same cycle. A flush input empties the window.

Top module: `issue_window_grouper`

## Requirements
- R1: The group is a contiguous run of window slots starting at slot 0 and holds at most four instructions. `issue_mask_o` bit i marks slot i and `issue_cnt_o` gives the size of the group. Grouping stops at the first slot that breaks any rule, and no slot after it issues.
- R2: Class codes are 0 for integer, 1 for FP/graphics, 2 for load/store and 3 for branch. A group holds at most two integer, two FP, one load/store and one branch instruction.
- R3: The fourth group position (slot 3) can issue only an FP or a branch instruction. Slots 0 to 2 accept any class.
- R4: An instruction does not join the group if either of its source registers is the destination of an older member of the group. There is one exception: a store (class 2 with the store flag set) may join when only its data source (`src_b`) matches, and the older producer is an integer instruction. Register 0 never creates a dependence.
- R5: Unit codes per slot are 0 and 1 for the first and second integer instruction of the group, 2 and 3 for the first and second FP instruction, 4 for load/store and 5 for branch. A slot that does not issue reports 7.
- R6: At the clock edge, the slots that did not issue move to the head in their original order. `issue_tag_o` reports the tag held in each slot.
- R7: The number of fetch instructions taken, `accept_cnt_o`, equals the smaller of `fetch_cnt_i` and the number of slots left free after the current group leaves. A count above four counts as four. The taken instructions are the lowest-numbered fetch entries, and they are placed in order behind the remaining ones.
- R8: A window with slot 0 empty issues nothing, and every slot then reports unit 7.
- R9: While `flush_i` is high, nothing issues and nothing is taken from fetch. In the next cycle the window is empty.
- R10: After reset the window is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty the window |
| fetch_cnt_i | input | 3 | Number of valid fetch entries |
| fetch_cls_i | input | 8 | Class code per fetch entry, 2 bits each |
| fetch_store_i | input | 4 | Store flag per fetch entry |
| fetch_dst_i | input | 20 | Destination register per entry, 0 = none |
| fetch_src_a_i | input | 20 | First source register per entry, 0 = none |
| fetch_src_b_i | input | 20 | Second source, store data, 0 = none |
| fetch_tag_i | input | 32 | Tag per fetch entry |
| accept_cnt_o | output | 3 | Fetch entries taken this cycle |
| issue_mask_o | output | 4 | Issue flag per window slot |
| issue_cnt_o | output | 3 | Size of the group |
| issue_unit_o | output | 12 | Unit code per slot, 3 bits each |
| issue_tag_o | output | 32 | Tag held in each window slot |

## Verification
Groups are built from a window of independent instructions, and the class mix is varied each time. One mix fills every position. Other mixes overflow the integer, FP, load/store or branch limit, and one puts an integer instruction in the fourth position. Comparing where each group stops shows which rule ended it. Dependent pairs then probe the dependence rule: a RAW on the first source, a RAW on the second source of a non-store, store data produced by an integer instruction, a store address produced by an integer instruction, store data produced by an FP instruction, and dependences through register 0. Together these separate the single legal case from the illegal ones. Refill and flush cases check three things: the leftover instructions stay ahead of the new ones, the accept count follows the number of free tail slots, and a flush removes the whole window.

// File: rtl/iw_pkg.sv
package iw_pkg;

  localparam int CLS_W  = 2;
  localparam int UNIT_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT = 2'd0,
    CLS_FP  = 2'd1,
    CLS_MEM = 2'd2,
    CLS_BR  = 2'd3
  } op_cls_e;

  localparam logic [UNIT_W-1:0] UNIT_INT0 = 3'd0;
  localparam logic [UNIT_W-1:0] UNIT_FP0  = 3'd2;
  localparam logic [UNIT_W-1:0] UNIT_MEM  = 3'd4;
  localparam logic [UNIT_W-1:0] UNIT_BR   = 3'd5;
  localparam logic [UNIT_W-1:0] UNIT_NONE = 3'd7;

  localparam int LIM_INT = 2;
  localparam int LIM_FP  = 2;
  localparam int LIM_MEM = 1;
  localparam int LIM_BR  = 1;

endpackage

// File: rtl/iw_group_sel.sv
module iw_group_sel
  import iw_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int REG_W     = 5
) (
  input  logic                  block_i,
  input  logic [NUM_SLOTS-1:0]  valid_i,
  input  op_cls_e               cls_i   [NUM_SLOTS],
  input  logic [NUM_SLOTS-1:0]  store_i,
  input  logic [REG_W-1:0]      dst_i   [NUM_SLOTS],
  input  logic [REG_W-1:0]      src_a_i [NUM_SLOTS],
  input  logic [REG_W-1:0]      src_b_i [NUM_SLOTS],
  output logic [NUM_SLOTS-1:0]  issue_o,
  output logic [UNIT_W-1:0]     unit_o  [NUM_SLOTS],
  output logic [$clog2(NUM_SLOTS+1)-1:0] cnt_o
);

  localparam int CNT_W = $clog2(NUM_SLOTS+1);

  logic [NUM_SLOTS-1:0] grp;
  logic [UNIT_W-1:0]    unit_q [NUM_SLOTS];

  always_comb begin
    int   n_int;
    int   n_fp;
    int   n_mem;
    int   n_br;
    logic open;
    logic ok;
    grp   = '0;
    n_int = 0;
    n_fp  = 0;
    n_mem = 0;
    n_br  = 0;
    open  = !block_i;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      unit_q[i] = UNIT_NONE;
      ok = open && valid_i[i];
      unique case (cls_i[i])
        CLS_INT: ok = ok && (n_int < LIM_INT);
        CLS_FP:  ok = ok && (n_fp  < LIM_FP);
        CLS_MEM: ok = ok && (n_mem < LIM_MEM);
        default: ok = ok && (n_br  < LIM_BR);
      endcase
      // last position: FP or branch only
      if (i == NUM_SLOTS-1)
        ok = ok && (cls_i[i] == CLS_FP || cls_i[i] == CLS_BR);
      for (int j = 0; j < i; j++) begin
        if (grp[j] && dst_i[j] != '0) begin
          logic hit_a;
          logic hit_b;
          hit_a = (src_a_i[i] == dst_i[j]);
          hit_b = (src_b_i[i] == dst_i[j]);
          if (hit_a) ok = 1'b0;
          // store data fed by an older integer op may pair
          if (hit_b && !(store_i[i] && cls_i[i] == CLS_MEM && cls_i[j] == CLS_INT))
            ok = 1'b0;
        end
      end
      if (ok) begin
        grp[i] = 1'b1;
        unique case (cls_i[i])
          CLS_INT: begin
            unit_q[i] = UNIT_W'(int'(UNIT_INT0) + n_int);
            n_int++;
          end
          CLS_FP: begin
            unit_q[i] = UNIT_W'(int'(UNIT_FP0) + n_fp);
            n_fp++;
          end
          CLS_MEM: begin
            unit_q[i] = UNIT_MEM;
            n_mem++;
          end
          default: begin
            unit_q[i] = UNIT_BR;
            n_br++;
          end
        endcase
      end
      open = ok;
    end
  end

  assign issue_o = grp;
  assign unit_o  = unit_q;
  assign cnt_o   = CNT_W'($countones(grp));

endmodule

// File: rtl/iw_slot_store.sv
module iw_slot_store
  import iw_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int REG_W     = 5,
  parameter int TAG_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic [$clog2(NUM_SLOTS+1)-1:0] issue_cnt_i,
  input  logic [$clog2(NUM_SLOTS+1)-1:0] fetch_cnt_i,
  input  op_cls_e               f_cls_i   [NUM_SLOTS],
  input  logic [NUM_SLOTS-1:0]  f_store_i,
  input  logic [REG_W-1:0]      f_dst_i   [NUM_SLOTS],
  input  logic [REG_W-1:0]      f_src_a_i [NUM_SLOTS],
  input  logic [REG_W-1:0]      f_src_b_i [NUM_SLOTS],
  input  logic [TAG_W-1:0]      f_tag_i   [NUM_SLOTS],
  output logic [$clog2(NUM_SLOTS+1)-1:0] accept_cnt_o,
  output logic [NUM_SLOTS-1:0]  valid_o,
  output op_cls_e               cls_o     [NUM_SLOTS],
  output logic [NUM_SLOTS-1:0]  store_o,
  output logic [REG_W-1:0]      dst_o     [NUM_SLOTS],
  output logic [REG_W-1:0]      src_a_o   [NUM_SLOTS],
  output logic [REG_W-1:0]      src_b_o   [NUM_SLOTS],
  output logic [TAG_W-1:0]      tag_o     [NUM_SLOTS]
);

  localparam int CNT_W = $clog2(NUM_SLOTS+1);

  typedef struct packed {
    logic             vld;
    op_cls_e          cls;
    logic             st;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] sa;
    logic [REG_W-1:0] sb;
    logic [TAG_W-1:0] tag;
  } entry_t;

  entry_t win_q [NUM_SLOTS];
  entry_t win_d [NUM_SLOTS];
  entry_t inc   [NUM_SLOTS];

  logic [CNT_W-1:0] occ_cnt;
  logic [CNT_W-1:0] take_cnt;
  logic [CNT_W-1:0] keep_cnt;
  logic [TAG_W-1:0] shift_tag;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_in
    always_comb begin
      inc[g].vld = 1'b1;
      inc[g].cls = f_cls_i[g];
      inc[g].st  = f_store_i[g];
      inc[g].dst = f_dst_i[g];
      inc[g].sa  = f_src_a_i[g];
      inc[g].sb  = f_src_b_i[g];
      inc[g].tag = f_tag_i[g];
    end
    assign valid_o[g] = win_q[g].vld;
    assign cls_o[g]   = win_q[g].cls;
    assign store_o[g] = win_q[g].st;
    assign dst_o[g]   = win_q[g].dst;
    assign src_a_o[g] = win_q[g].sa;
    assign src_b_o[g] = win_q[g].sb;
    assign tag_o[g]   = win_q[g].tag;
  end

  always_comb begin
    int occ;
    int keep;
    int take;
    int src;
    occ = 0;
    for (int i = 0; i < NUM_SLOTS; i++) occ += int'(win_q[i].vld);
    keep = occ - int'(issue_cnt_i);
    if (keep < 0) keep = 0;
    take = (int'(fetch_cnt_i) > NUM_SLOTS) ? NUM_SLOTS : int'(fetch_cnt_i);
    if (take > NUM_SLOTS - keep) take = NUM_SLOTS - keep;
    if (flush_i) take = 0;
    shift_tag = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      win_d[i] = '0;
      src = i + int'(issue_cnt_i);
      if (i < keep) begin
        if (src < NUM_SLOTS) win_d[i] = win_q[src];
      end else if (i < keep + take) begin
        win_d[i] = inc[i - keep];
      end
      if (flush_i) win_d[i] = '0;
      if (i == int'(issue_cnt_i)) shift_tag = win_q[i].tag;
    end
    occ_cnt  = CNT_W'(occ);
    keep_cnt = CNT_W'(keep);
    take_cnt = CNT_W'(take);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SLOTS; i++) win_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) win_q[i] <= win_d[i];
    end
  end

  assign accept_cnt_o = take_cnt;

  // R9
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_o == '0));

  // R7
  occ_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (int'(occ_cnt) == int'($past(keep_cnt)) + int'($past(take_cnt))));

  // R6
  head_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && issue_cnt_i != '0 && keep_cnt != '0) |=> (tag_o[0] == $past(shift_tag)));

endmodule

// File: rtl/issue_window_grouper.sv
module issue_window_grouper
  import iw_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int REG_W     = 5,
  parameter int TAG_W     = 8,
  localparam int CNT_W    = $clog2(NUM_SLOTS+1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic [CNT_W-1:0]             fetch_cnt_i,
  input  logic [NUM_SLOTS*CLS_W-1:0]   fetch_cls_i,
  input  logic [NUM_SLOTS-1:0]         fetch_store_i,
  input  logic [NUM_SLOTS*REG_W-1:0]   fetch_dst_i,
  input  logic [NUM_SLOTS*REG_W-1:0]   fetch_src_a_i,
  input  logic [NUM_SLOTS*REG_W-1:0]   fetch_src_b_i,
  input  logic [NUM_SLOTS*TAG_W-1:0]   fetch_tag_i,
  output logic [CNT_W-1:0]             accept_cnt_o,
  output logic [NUM_SLOTS-1:0]         issue_mask_o,
  output logic [CNT_W-1:0]             issue_cnt_o,
  output logic [NUM_SLOTS*UNIT_W-1:0]  issue_unit_o,
  output logic [NUM_SLOTS*TAG_W-1:0]   issue_tag_o
);

  op_cls_e          f_cls [NUM_SLOTS];
  logic [REG_W-1:0] f_dst [NUM_SLOTS];
  logic [REG_W-1:0] f_sa  [NUM_SLOTS];
  logic [REG_W-1:0] f_sb  [NUM_SLOTS];
  logic [TAG_W-1:0] f_tag [NUM_SLOTS];

  logic [NUM_SLOTS-1:0] w_vld;
  op_cls_e              w_cls [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] w_st;
  logic [REG_W-1:0]     w_dst [NUM_SLOTS];
  logic [REG_W-1:0]     w_sa  [NUM_SLOTS];
  logic [REG_W-1:0]     w_sb  [NUM_SLOTS];
  logic [TAG_W-1:0]     w_tag [NUM_SLOTS];

  logic [UNIT_W-1:0]    unit  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] mem_hit;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flat
    assign f_cls[g] = op_cls_e'(fetch_cls_i[g*CLS_W +: CLS_W]);
    assign f_dst[g] = fetch_dst_i[g*REG_W +: REG_W];
    assign f_sa[g]  = fetch_src_a_i[g*REG_W +: REG_W];
    assign f_sb[g]  = fetch_src_b_i[g*REG_W +: REG_W];
    assign f_tag[g] = fetch_tag_i[g*TAG_W +: TAG_W];
    assign issue_unit_o[g*UNIT_W +: UNIT_W] = unit[g];
    assign issue_tag_o[g*TAG_W +: TAG_W]    = w_tag[g];
    assign mem_hit[g] = (unit[g] == UNIT_MEM);
  end

  iw_slot_store #(
    .NUM_SLOTS (NUM_SLOTS),
    .REG_W     (REG_W),
    .TAG_W     (TAG_W)
  ) i_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .issue_cnt_i  (issue_cnt_o),
    .fetch_cnt_i  (fetch_cnt_i),
    .f_cls_i      (f_cls),
    .f_store_i    (fetch_store_i),
    .f_dst_i      (f_dst),
    .f_src_a_i    (f_sa),
    .f_src_b_i    (f_sb),
    .f_tag_i      (f_tag),
    .accept_cnt_o (accept_cnt_o),
    .valid_o      (w_vld),
    .cls_o        (w_cls),
    .store_o      (w_st),
    .dst_o        (w_dst),
    .src_a_o      (w_sa),
    .src_b_o      (w_sb),
    .tag_o        (w_tag)
  );

  iw_group_sel #(
    .NUM_SLOTS (NUM_SLOTS),
    .REG_W     (REG_W)
  ) i_sel (
    .block_i (flush_i),
    .valid_i (w_vld),
    .cls_i   (w_cls),
    .store_i (w_st),
    .dst_i   (w_dst),
    .src_a_i (w_sa),
    .src_b_i (w_sb),
    .issue_o (issue_mask_o),
    .unit_o  (unit),
    .cnt_o   (issue_cnt_o)
  );

  // R3
  last_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_mask_o[NUM_SLOTS-1] |-> (w_cls[NUM_SLOTS-1] == CLS_FP || w_cls[NUM_SLOTS-1] == CLS_BR));

  // R2
  mem_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mem_hit) <= LIM_MEM);

  // R8
  empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !w_vld[0] |-> (issue_mask_o == '0));

  for (genvar g = 1; g < NUM_SLOTS; g++) begin : g_pfx
    // R1
    prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_mask_o[g] |-> issue_mask_o[g-1]);
  end

endmodule

// File: tb/test_issue_window_grouper.sv
`timescale 1ns/1ps
module test_issue_window_grouper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [2:0]  f_cnt = '0;
  logic [7:0]  fetch_cls;
  logic [3:0]  fetch_store;
  logic [19:0] fetch_dst, fetch_sa, fetch_sb;
  logic [31:0] fetch_tag;
  logic [2:0]  accept_cnt, issue_cnt;
  logic [3:0]  issue_mask;
  logic [11:0] issue_unit;
  logic [31:0] issue_tag;

  logic [1:0] a_cls [4];
  logic       a_st  [4];
  logic [4:0] a_dst [4];
  logic [4:0] a_sa  [4];
  logic [4:0] a_sb  [4];
  logic [7:0] a_tag [4];

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      fetch_cls[i*2 +: 2] = a_cls[i];
      fetch_store[i]      = a_st[i];
      fetch_dst[i*5 +: 5] = a_dst[i];
      fetch_sa[i*5 +: 5]  = a_sa[i];
      fetch_sb[i*5 +: 5]  = a_sb[i];
      fetch_tag[i*8 +: 8] = a_tag[i];
    end
  end

  issue_window_grouper i_issue_window_grouper (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .flush_i       (flush),
    .fetch_cnt_i   (f_cnt),
    .fetch_cls_i   (fetch_cls),
    .fetch_store_i (fetch_store),
    .fetch_dst_i   (fetch_dst),
    .fetch_src_a_i (fetch_sa),
    .fetch_src_b_i (fetch_sb),
    .fetch_tag_i   (fetch_tag),
    .accept_cnt_o  (accept_cnt),
    .issue_mask_o  (issue_mask),
    .issue_cnt_o   (issue_cnt),
    .issue_unit_o  (issue_unit),
    .issue_tag_o   (issue_tag)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unit_at(int i);
    return int'(issue_unit[i*3 +: 3]);
  endfunction

  function automatic int tag_at(int i);
    return int'(issue_tag[i*8 +: 8]);
  endfunction

  task automatic chk_grp(string req, int mask);
    chk(req, "issue mask", int'(issue_mask), mask);
    chk(req, "issue count", int'(issue_cnt), $countones(mask[3:0]));
  endtask

  task automatic put(int i, int cls, int st, int dst, int sa, int sb, int tag);
    a_cls[i] = 2'(cls);
    a_st[i]  = st[0];
    a_dst[i] = 5'(dst);
    a_sa[i]  = 5'(sa);
    a_sb[i]  = 5'(sb);
    a_tag[i] = 8'(tag);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic flush_win();
    flush = 1'b1;
    f_cnt = '0;
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
    #1;
  endtask

  // window is empty on entry: all n entries must be taken (R7)
  task automatic fill(int n);
    f_cnt = 3'(n);
    #1;
    chk("R7", "accept on empty window", int'(accept_cnt), (n > 4) ? 4 : n);
    @(posedge clk);
    @(negedge clk);
    f_cnt = '0;
    #1;
  endtask

  task automatic t_reset();
    chk("R10", "mask after reset", int'(issue_mask), 0);
    chk("R8", "count on empty", int'(issue_cnt), 0);
    chk("R8", "unit slot0 on empty", unit_at(0), 7);
    chk("R7", "accept with zero offered", int'(accept_cnt), 0);
    f_cnt = 3'd6;
    #1;
    chk("R7", "accept capped at four", int'(accept_cnt), 4);
    f_cnt = '0;
    #1;
  endtask

  task automatic t_full_mix();
    flush_win();
    put(0, 0, 0, 1, 2, 3, 10);
    put(1, 0, 0, 4, 5, 6, 11);
    put(2, 2, 0, 7, 8, 0, 12);
    put(3, 3, 0, 0, 9, 0, 13);
    fill(4);
    chk_grp("R1", 4'b1111);
    chk("R5", "unit slot0 int", unit_at(0), 0);
    chk("R5", "unit slot1 int", unit_at(1), 1);
    chk("R5", "unit slot2 mem", unit_at(2), 4);
    chk("R5", "unit slot3 br", unit_at(3), 5);
    chk("R6", "tag slot3", tag_at(3), 13);
    step();
    chk_grp("R8", 4'b0000);
  endtask

  task automatic t_limits();
    flush_win();
    put(0, 0, 0, 1, 2, 3, 20);
    put(1, 0, 0, 4, 5, 6, 21);
    put(2, 0, 0, 7, 8, 9, 22);
    put(3, 1, 0, 10, 11, 12, 23);
    fill(4);
    chk_grp("R2", 4'b0011);
    chk("R5", "unit of blocked slot", unit_at(2), 7);
    step();
    chk_grp("R6", 4'b0011);
    chk("R6", "head tag after shift", tag_at(0), 22);
    chk("R6", "slot1 tag after shift", tag_at(1), 23);
    chk("R5", "fp unit after shift", unit_at(1), 2);

    flush_win();
    put(0, 2, 0, 1, 2, 0, 24);
    put(1, 2, 0, 3, 4, 0, 25);
    fill(2);
    chk_grp("R2", 4'b0001);

    flush_win();
    put(0, 3, 0, 0, 1, 0, 26);
    put(1, 3, 0, 0, 2, 0, 27);
    fill(2);
    chk_grp("R2", 4'b0001);

    flush_win();
    put(0, 1, 0, 1, 2, 3, 28);
    put(1, 1, 0, 4, 5, 6, 29);
    put(2, 1, 0, 7, 8, 9, 30);
    fill(3);
    chk_grp("R2", 4'b0011);
  endtask

  task automatic t_last_slot();
    flush_win();
    put(0, 0, 0, 1, 2, 3, 31);
    put(1, 1, 0, 4, 5, 6, 32);
    put(2, 2, 0, 7, 8, 0, 33);
    put(3, 0, 0, 9, 10, 11, 34);
    fill(4);
    chk_grp("R3", 4'b0111);
    step();
    chk_grp("R3", 4'b0001);
    chk("R6", "leftover at head", tag_at(0), 34);

    flush_win();
    put(0, 1, 0, 1, 2, 3, 35);
    put(1, 0, 0, 4, 5, 6, 36);
    put(2, 0, 0, 7, 8, 9, 37);
    put(3, 1, 0, 10, 11, 12, 38);
    fill(4);
    chk_grp("R3", 4'b1111);
    chk("R5", "unit slot0 fp0", unit_at(0), 2);
    chk("R5", "unit slot2 int1", unit_at(2), 1);
    chk("R5", "unit slot3 fp1", unit_at(3), 3);
  endtask

  task automatic t_raw();
    flush_win();
    put(0, 0, 0, 5, 1, 2, 40);
    put(1, 0, 0, 6, 5, 0, 41);
    put(2, 0, 0, 0, 0, 0, 99);
    fill(2);
    chk_grp("R4", 4'b0001);
    step();
    chk_grp("R4", 4'b0001);
    chk("R6", "dependent op now at head", tag_at(0), 41);
    step();
    chk_grp("R7", 4'b0000);

    flush_win();
    put(0, 0, 0, 0, 1, 2, 42);
    put(1, 0, 0, 3, 0, 0, 43);
    fill(2);
    chk_grp("R4", 4'b0011);

    flush_win();
    put(0, 0, 0, 5, 1, 2, 44);
    put(1, 1, 0, 6, 1, 5, 45);
    fill(2);
    chk_grp("R4", 4'b0001);
  endtask

  task automatic t_store();
    flush_win();
    put(0, 0, 0, 5, 1, 2, 46);
    put(1, 2, 1, 0, 3, 5, 47);
    fill(2);
    chk_grp("R4", 4'b0011);
    chk("R5", "store unit", unit_at(1), 4);

    flush_win();
    put(0, 0, 0, 5, 1, 2, 48);
    put(1, 2, 1, 0, 5, 2, 49);
    fill(2);
    chk_grp("R4", 4'b0001);

    flush_win();
    put(0, 1, 0, 5, 1, 2, 50);
    put(1, 2, 1, 0, 3, 5, 51);
    fill(2);
    chk_grp("R4", 4'b0001);
  endtask

  task automatic t_refill();
    flush_win();
    put(0, 0, 0, 1, 2, 3, 52);
    put(1, 0, 0, 4, 5, 6, 53);
    put(2, 0, 0, 7, 8, 9, 54);
    put(3, 1, 0, 10, 11, 12, 55);
    fill(4);
    put(0, 3, 0, 0, 13, 0, 60);
    put(1, 0, 0, 14, 15, 16, 61);
    put(2, 1, 0, 17, 18, 19, 62);
    put(3, 1, 0, 20, 21, 22, 63);
    f_cnt = 3'd4;
    #1;
    chk_grp("R1", 4'b0011);
    chk("R7", "accept two after group of two", int'(accept_cnt), 2);
    step();
    chk_grp("R3", 4'b0111);
    chk("R6", "old op first", tag_at(0), 54);
    chk("R6", "old op second", tag_at(1), 55);
    chk("R7", "new op behind", tag_at(2), 60);
    chk("R7", "second new op", tag_at(3), 61);
    chk("R5", "branch unit", unit_at(2), 5);
    chk("R7", "accept three after group of three", int'(accept_cnt), 3);
    f_cnt = '0;
    #1;
  endtask

  task automatic t_flush();
    flush_win();
    put(0, 0, 0, 1, 2, 3, 80);
    put(1, 0, 0, 4, 5, 6, 81);
    put(2, 1, 0, 7, 8, 9, 82);
    put(3, 1, 0, 10, 11, 12, 83);
    fill(4);
    flush = 1'b1;
    f_cnt = 3'd4;
    #1;
    chk_grp("R9", 4'b0000);
    chk("R9", "accept during flush", int'(accept_cnt), 0);
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
    f_cnt = '0;
    #1;
    chk_grp("R9", 4'b0000);
    chk("R8", "unit slot0 after flush", unit_at(0), 7);
    f_cnt = 3'd3;
    #1;
    chk("R9", "accept into emptied window", int'(accept_cnt), 3);
    f_cnt = '0;
    #1;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) put(i, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_full_mix();
    t_limits();
    t_last_slot();
    t_raw();
    t_store();
    t_refill();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule